// File: doc/BRIEF.md
# Seconds Counter with Compare Alarm

This block keeps wall time as a 32-bit count of seconds. It advances by one on every cycle in which the one-per-second strobe is high and the run bit is set. It is reached over a plain byte-wide register port with an address, a write strobe, a read strobe and 8-bit data.

A new time is never written straight into the running count. Software stops the counter and writes the upper three bytes into a staging area. The write of the least significant byte then moves all four bytes into the counter in one cycle. The live count can be read one byte at a time. A reader guards against a carry between byte reads by reading the low byte again and repeating the whole read if that value went down.

A 32-bit compare value raises a sticky alarm status when it matches the count while the alarm is enabled. The interrupt line is that status masked by the enable. Software acknowledges the alarm by writing a clear bit in a second control register. The register bus is a control path with no flow of data, so it has no valid/ready handshake. A read returns its byte one cycle after the strobe, marked by a one-cycle valid pulse.

Top module: `secrtc_top`

## Requirements
- R1: After reset the counter, the alarm value, the staging bytes, the run bit, the alarm enable and the alarm status are all zero, and `alarm_irq` is low.
- R2: Bit 7 of the control register at offset 0x00 is the run bit. When it is set, each cycle with `tick_1hz` high adds one to the count. When it is clear, the count holds its value.
- R3: Writes to offsets 0x03, 0x04 and 0x05 change only the staging bytes 1 to 3 and leave the count untouched. A write of value d to offset 0x02 loads the count with {stage3, stage2, stage1, d} at that clock edge.
- R4: The count wraps from 0xFFFFFFFF to 0x00000000 on a tick.
- R5: The compare value is readable and writable as four bytes at offsets 0x0A to 0x0D, with the least significant byte at 0x0A.
- R6: Bit 1 of the control register enables the alarm. If the enable is set and the count equals the compare value in one cycle, the status bit (bit 0 of offset 0x01) is set on the following edge. `alarm_irq` is the status ANDed with the enable.
- R7: The status stays set until 1 is written to bit 0 of offset 0x01. That clear takes precedence over a set in the same cycle. Clearing the enable masks `alarm_irq` but keeps the status.
- R8: With the alarm enable clear, a match between the count and the compare value never sets the status.
- R9: A read strobe returns the addressed byte on `bus_rdata`, with `bus_rvalid` high for one cycle, on the edge after the strobe. The control register reads back only bits 7 and 1. The live count is at offsets 0x06 to 0x09, least significant byte first. Offsets 0x0E and 0x0F read as zero.
- R10: A load (a write to offset 0x02) in the same cycle as a counting tick wins, and the count takes the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle strobe per second |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | One-cycle pulse marking read data |
| alarm_irq | output | 1 | Level alarm interrupt |

## Verification
The hardest case to reach from the ports is a carry that lands between two byte reads of the live count. The stimulus loads a count of 0x000000FF, reads the low byte, sends one tick and reads the low byte again. The second value is lower than the first, so the reader repeats the read and must get 0x00000100.

The alarm edge is also awkward, because the status lags the match by one register. The bench puts the count one below the compare value and ticks once. It then samples the interrupt in the cycle of the match and in the cycle after. The bench also repeats the acknowledge sequence with the counter stopped on a matching value, where a clear with the enable still set would re-raise the alarm.

// File: rtl/secrtc_pkg.sv
package secrtc_pkg;
  localparam int unsigned CTRL_OFS  = 0;
  localparam int unsigned ACK_OFS   = 1;
  localparam int unsigned STAGE_OFS = 2;
  localparam int unsigned RUN_BIT   = 7;
  localparam int unsigned AEN_BIT   = 1;
  localparam int unsigned ACK_BIT   = 0;

  typedef enum logic [2:0] {
    RG_CTRL,
    RG_ACK,
    RG_STAGE,
    RG_LIVE,
    RG_CMP,
    RG_NONE
  } region_e;
endpackage

// File: rtl/secrtc_counter.sv
module secrtc_counter #(
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic              load,
  input  logic [TIME_W-1:0] load_val,
  output logic [TIME_W-1:0] cnt
);
  logic [TIME_W-1:0] cnt_q;

  // a load outranks a tick arriving in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (run && tick)
      cnt_q <= cnt_q + TIME_W'(1);
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/secrtc_alarm.sv
module secrtc_alarm #(
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              ack,
  input  logic [TIME_W-1:0] cnt,
  input  logic [TIME_W-1:0] cmp,
  output logic              pend,
  output logic              irq
);
  logic pend_q;
  logic hit;

  assign hit = enable && (cnt == cmp);

  // acknowledge wins; a persisting match sets the status again a cycle later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pend_q <= 1'b0;
    else if (ack)
      pend_q <= 1'b0;
    else if (hit)
      pend_q <= 1'b1;
  end

  assign pend = pend_q;
  assign irq  = pend_q & enable;
endmodule

// File: rtl/secrtc_regbank.sv
module secrtc_regbank
  import secrtc_pkg::*;
#(
  parameter int TIME_W = 32,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              rvalid,
  input  logic [TIME_W-1:0] cnt,
  input  logic              pend,
  output logic              run_en,
  output logic              alm_en,
  output logic [TIME_W-1:0] cmp_val,
  output logic              load,
  output logic [TIME_W-1:0] load_val,
  output logic              ack
);
  localparam int NB        = TIME_W / BYTE_W;
  localparam int IW        = (NB > 1) ? $clog2(NB) : 1;
  localparam int LIVE_OFS  = STAGE_OFS + NB;
  localparam int CMP_OFS   = LIVE_OFS + NB;

  logic [BYTE_W-1:0] stage_q [NB];
  logic [BYTE_W-1:0] cmp_q   [NB];
  logic              run_q, aen_q;
  logic [BYTE_W-1:0] rdata_q, rd_mux;
  logic              rvalid_q;
  region_e           region;
  logic [IW-1:0]     idx;

  always_comb begin
    int unsigned a;
    a      = int'(addr);
    region = RG_NONE;
    idx    = '0;
    if (a == CTRL_OFS) begin
      region = RG_CTRL;
    end else if (a == ACK_OFS) begin
      region = RG_ACK;
    end else if (a >= STAGE_OFS && a < LIVE_OFS) begin
      region = RG_STAGE;
      idx    = IW'(a - STAGE_OFS);
    end else if (a >= LIVE_OFS && a < CMP_OFS) begin
      region = RG_LIVE;
      idx    = IW'(a - LIVE_OFS);
    end else if (a >= CMP_OFS && a < CMP_OFS + NB) begin
      region = RG_CMP;
      idx    = IW'(a - CMP_OFS);
    end
  end

  assign load = wr && (region == RG_STAGE) && (idx == '0);
  assign ack  = wr && (region == RG_ACK) && wdata[ACK_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      aen_q <= 1'b0;
    end else if (wr && region == RG_CTRL) begin
      run_q <= wdata[RUN_BIT];
      aen_q <= wdata[AEN_BIT];
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        stage_q[g] <= '0;
      else if (wr && region == RG_STAGE && idx == IW'(g))
        stage_q[g] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cmp_q[g] <= '0;
      else if (wr && region == RG_CMP && idx == IW'(g))
        cmp_q[g] <= wdata;
    end

    assign cmp_val[g*BYTE_W +: BYTE_W] = cmp_q[g];

    // byte 0 of the loaded word comes straight from the bus
    if (g == 0) begin : g_lsb
      assign load_val[BYTE_W-1:0] = wdata;
    end else begin : g_upper
      assign load_val[g*BYTE_W +: BYTE_W] = stage_q[g];
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (region)
      RG_CTRL: begin
        rd_mux[RUN_BIT] = run_q;
        rd_mux[AEN_BIT] = aen_q;
      end
      RG_ACK:   rd_mux[ACK_BIT] = pend;
      RG_STAGE: rd_mux = stage_q[idx];
      RG_LIVE:  rd_mux = cnt[idx*BYTE_W +: BYTE_W];
      RG_CMP:   rd_mux = cmp_q[idx];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd;
      if (rd)
        rdata_q <= rd_mux;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;
  assign run_en = run_q;
  assign alm_en = aen_q;
endmodule

// File: rtl/secrtc_top.sv
module secrtc_top #(
  parameter int TIME_W = 32,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              alarm_irq
);
  logic [TIME_W-1:0] cnt_q;
  logic [TIME_W-1:0] cmp_val;
  logic [TIME_W-1:0] load_val;
  logic              run_en, alm_en, alm_pend, load, ack;

  secrtc_regbank #(
    .TIME_W(TIME_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .wdata(bus_wdata),
    .rdata(bus_rdata), .rvalid(bus_rvalid),
    .cnt(cnt_q), .pend(alm_pend),
    .run_en(run_en), .alm_en(alm_en), .cmp_val(cmp_val),
    .load(load), .load_val(load_val), .ack(ack)
  );

  secrtc_counter #(.TIME_W(TIME_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .run(run_en), .tick(tick_1hz),
    .load(load), .load_val(load_val),
    .cnt(cnt_q)
  );

  secrtc_alarm #(.TIME_W(TIME_W)) u_alm (
    .clk(clk), .rst_n(rst_n),
    .enable(alm_en), .ack(ack),
    .cnt(cnt_q), .cmp(cmp_val),
    .pend(alm_pend), .irq(alarm_irq)
  );
endmodule

// File: rtl/secrtc_chk.sv
module secrtc_chk #(
  parameter int TIME_W = 32,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic              bus_rvalid,
  input logic              alarm_irq,
  input logic [TIME_W-1:0] cnt,
  input logic [TIME_W-1:0] cmp,
  input logic              run,
  input logic              aen,
  input logic              pend
);
  logic ld, clr, hit;
  assign ld  = bus_wr && (bus_addr == ADDR_W'(2));
  assign clr = bus_wr && (bus_addr == ADDR_W'(1)) && bus_wdata[0];
  assign hit = aen && (cnt == cmp);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld) |=> $stable(cnt));

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !ld) |=> (cnt == $past(cnt) + TIME_W'(1)));

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt[BYTE_W-1:0] == $past(bus_wdata)));

  p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !clr) |=> pend);

  p_noset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && !hit) |=> !pend);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pend);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr) |=> pend);

  p_irq_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |-> !alarm_irq);

  p_rvalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  p_rvalid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);
endmodule

bind secrtc_top secrtc_chk #(
  .TIME_W(TIME_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_1hz),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .alarm_irq(alarm_irq),
  .cnt(cnt_q), .cmp(cmp_val), .run(run_en), .aen(alm_en), .pend(alm_pend)
);

// File: tb/secrtc_top_tb.sv
module secrtc_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       bus_rvalid;
  logic       alarm_irq;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;
  logic last_rvalid;

  always #2 clk = ~clk;

  secrtc_top u_dut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .alarm_irq(alarm_irq)
  );

  // fields: req[25:22] op[21:20] addr[19:16] data[15:8] exp[7:0]
  // op 0 = write, 1 = read and compare, 2 = one tick
  localparam int NV = 22;
  localparam logic [25:0] VEC [NV] = '{
    {4'd3, 2'd0, 4'h0, 8'h00, 8'h00},  // R3 stop the counter
    {4'd3, 2'd0, 4'h2, 8'h00, 8'h00},  // R3 byte 0 as zero first
    {4'd3, 2'd0, 4'h3, 8'h22, 8'h00},
    {4'd3, 2'd0, 4'h4, 8'h33, 8'h00},
    {4'd3, 2'd1, 4'h6, 8'h00, 8'h00},  // R3 staging leaves count alone
    {4'd3, 2'd0, 4'h5, 8'h44, 8'h00},
    {4'd3, 2'd0, 4'h2, 8'h11, 8'h00},  // R3 commit
    {4'd9, 2'd1, 4'h6, 8'h00, 8'h11},  // R9 live bytes, LSB first
    {4'd9, 2'd1, 4'h7, 8'h00, 8'h22},
    {4'd9, 2'd1, 4'h8, 8'h00, 8'h33},
    {4'd9, 2'd1, 4'h9, 8'h00, 8'h44},
    {4'd2, 2'd2, 4'h0, 8'h00, 8'h00},  // R2 tick while stopped
    {4'd2, 2'd1, 4'h6, 8'h00, 8'h11},
    {4'd2, 2'd0, 4'h0, 8'h80, 8'h00},  // R2 run
    {4'd2, 2'd2, 4'h0, 8'h00, 8'h00},
    {4'd2, 2'd1, 4'h6, 8'h00, 8'h12},
    {4'd5, 2'd0, 4'hA, 8'h5A, 8'h00},  // R5 compare bytes
    {4'd5, 2'd0, 4'hD, 8'hA5, 8'h00},
    {4'd5, 2'd1, 4'hA, 8'h00, 8'h5A},
    {4'd5, 2'd1, 4'hD, 8'h00, 8'hA5},
    {4'd9, 2'd1, 4'h0, 8'hFF, 8'h80},  // R9 control readback
    {4'd9, 2'd1, 4'hE, 8'h00, 8'h00}   // R9 unmapped
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
    last_rvalid = bus_rvalid;
  endtask

  task automatic tick1();
    @(negedge clk);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  task automatic rd32(input logic [3:0] base, output logic [31:0] v);
    logic [7:0] b;
    for (int k = 0; k < 4; k++) begin
      rd(base + 4'(k), b);
      v[k*8 +: 8] = b;
    end
  endtask

  task automatic load32(input logic [31:0] v);
    wr(4'h2, 8'h00);
    wr(4'h3, v[15:8]);
    wr(4'h4, v[23:16]);
    wr(4'h5, v[31:24]);
    wr(4'h2, v[7:0]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog all-reqs actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b, b2;
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd32(4'h6, w);   check("R1 count", w, 32'h0);
    rd32(4'hA, w);   check("R1 compare", w, 32'h0);
    rd(4'h0, b);     check("R1 ctrl", {24'h0, b}, 32'h0);
    rd(4'h1, b);     check("R1 status", {24'h0, b}, 32'h0);
    check("R1 irq", {31'h0, alarm_irq}, 32'h0);
    check("R9 rvalid", {31'h0, last_rvalid}, 32'h1);
    @(negedge clk);
    check("R9 rvalid one cycle", {31'h0, bus_rvalid}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] rq;
      rq = VEC[i][25:22];
      case (VEC[i][21:20])
        2'd0: wr(VEC[i][19:16], VEC[i][15:8]);
        2'd1: begin
          rd(VEC[i][19:16], b);
          check($sformatf("R%0d vec%0d", rq, i), {24'h0, b}, {24'h0, VEC[i][7:0]});
        end
        default: tick1();
      endcase
    end

    // R4 wrap
    wr(4'h0, 8'h00);
    load32(32'hFFFF_FFFF);
    wr(4'h0, 8'h80);
    tick1();
    rd32(4'h6, w);   check("R4 wrap", w, 32'h0);

    // R10 load and tick together; stage bytes still FF
    @(negedge clk);
    bus_addr = 4'h2; bus_wdata = 8'h33; bus_wr = 1'b1; tick_1hz = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick_1hz = 1'b0;
    rd32(4'h6, w);   check("R10 load wins", w, 32'hFFFF_FF33);

    // R2 carry between byte reads, reader retries
    wr(4'h0, 8'h00);
    load32(32'h0000_00FF);
    wr(4'h0, 8'h80);
    rd(4'h6, b);
    tick1();
    rd(4'h6, b2);
    check("R2 lsb went down", {31'h0, (b2 < b)}, 32'h1);
    rd32(4'h6, w);   check("R2 reread", w, 32'h0000_0100);

    // R6 alarm edge
    wr(4'h0, 8'h00);
    wr(4'hA, 8'h05); wr(4'hB, 8'h01); wr(4'hC, 8'h00); wr(4'hD, 8'h00);
    load32(32'h0000_0104);
    wr(4'h0, 8'h82);
    check("R6 no early irq", {31'h0, alarm_irq}, 32'h0);
    tick1();
    check("R6 irq lags match", {31'h0, alarm_irq}, 32'h0);
    @(negedge clk);
    check("R6 irq raised", {31'h0, alarm_irq}, 32'h1);

    // R7 sticky, masking, clear
    tick1();
    check("R7 sticky", {31'h0, alarm_irq}, 32'h1);
    wr(4'h0, 8'h80);
    check("R7 masked", {31'h0, alarm_irq}, 32'h0);
    rd(4'h1, b);     check("R7 status kept", {24'h0, b}, 32'h1);
    wr(4'h1, 8'h01);
    rd(4'h1, b);     check("R7 cleared", {24'h0, b}, 32'h0);

    // R8 match with alarm disabled, counter stopped
    wr(4'h0, 8'h00);
    load32(32'h0000_0105);
    repeat (3) @(negedge clk);
    rd(4'h1, b);     check("R8 no status", {24'h0, b}, 32'h0);
    check("R8 no irq", {31'h0, alarm_irq}, 32'h0);
    wr(4'h0, 8'h02);
    @(negedge clk);
    check("R6 enable on match", {31'h0, alarm_irq}, 32'h1);
    wr(4'h0, 8'h00);
    wr(4'h1, 8'h01);
    rd(4'h1, b);     check("R7 handler clear", {24'h0, b}, 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule